// File: doc/BRIEF.md
# Multi-Step Fibonacci Shift-Register Sequence Generator

This block is a Fibonacci-form linear feedback shift register that performs several single shifts in each clock cycle. It therefore delivers a word of consecutive sequence bits per cycle instead of one bit. The register width, the feedback tap mask and the number of steps per cycle are parameters. The multi-step next state is built by chaining copies of the one-step feedback as combinational logic. The storage stays at exactly the register width, whatever the step count.

Cell 0 holds the current output bit, and every cell shifts one place toward cell 0. The top cell receives the XOR of the cells selected by the tap mask. Output lane j is cell j at the start of the cycle. Within one cycle, the lanes carry consecutive sequence bits. Over many cycles, lane j carries the sequence decimated by the step count with offset j.

A seed can be loaded at any time. A seed of all zeros would lock the register, so it is replaced by a nonzero default.

Top module: `lfsr_multistep`

## Requirements
- R1: While synchronous reset is high at a clock edge, the register takes the value DEFAULT_SEED. After reset, the output word is the low STEPS bits of DEFAULT_SEED.
- R2: In a cycle with enable high and load low, the register advances exactly STEPS single steps. One single step moves every cell i+1 into cell i and puts the XOR of the cells set in TAPS into cell WIDTH-1.
- R3: In a cycle with load high and a nonzero seed, the register takes the seed. The output word after that edge is the low STEPS bits of the seed.
- R4: In a cycle with load high and an all-zero seed, the register takes DEFAULT_SEED instead of zero.
- R5: Load has priority over enable. When both are high, the register takes the seed and does not advance.
- R6: When load and enable are both low, the register and the output word hold their values.
- R7: Output bit j is cell j. Across bits 0 to STEPS-1, one cycle's word holds consecutive sequence bits, lowest bit first. With a primitive tap set and STEPS coprime to 2^WIDTH-1, the word sequence repeats every 2^WIDTH-1 enabled cycles.
- R8: For WIDTH=4, TAPS=4'b1001 and STEPS=2, one enabled cycle computes the following next state:
  - x3 gets x3^x0^x1
  - x2 gets x3^x0
  - x1 gets x3
  - x0 gets x2

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Load strobe for the seed |
| seed | input | WIDTH | Seed value, with zero replaced by the default |
| en | input | 1 | Advance STEPS single steps this cycle |
| lanes | output | STEPS | Registered output word, with bit j equal to cell j |

## Verification
The hardest condition to reach from the ports is a hold cycle. During a hold, only the low STEPS bits of the register are visible, so an unwanted internal shift of the upper cells may not show on the lanes straight away. The bench idles the block and then resumes stepping, comparing every later word against a reference register stepped one bit at a time. Any hidden drift in the upper cells then shows up within a few cycles. The zero-seed case and the full-period wrap are reached by loading zero directly and by running 255 enabled cycles from a recorded start point.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  // Operation chosen for the state register in one cycle, in priority order
  typedef enum logic [1:0] {
    OP_HOLD    = 2'd0,
    OP_ADVANCE = 2'd1,
    OP_LOAD    = 2'd2
  } lfsr_op_e;
endpackage

// File: rtl/lfsr_step.sv
// One single shift of a Fibonacci register: cells move toward cell 0,
// and the top cell takes the parity of the tapped cells.
module lfsr_step #(
  parameter int unsigned           WIDTH = 8,
  parameter logic [WIDTH-1:0]      TAPS  = 8'b0111_0001
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);
  logic feedback;

  assign feedback = ^(cur & TAPS);

  generate
    if (WIDTH > 1) begin : g_shift
      assign nxt = {feedback, cur[WIDTH-1:1]};
    end else begin : g_single
      assign nxt = feedback;
    end
  endgenerate
endmodule

// File: rtl/lfsr_unroll.sv
// Chain of STEPS single-step stages giving the multi-step next state.
module lfsr_unroll #(
  parameter int unsigned      WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS  = 8'b0111_0001,
  parameter int unsigned      STEPS = 4
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);
  logic [WIDTH-1:0] chain [STEPS+1];

  assign chain[0] = cur;

  generate
    for (genvar k = 0; k < STEPS; k++) begin : g_stage
      lfsr_step #(
        .WIDTH(WIDTH),
        .TAPS (TAPS)
      ) step_i (
        .cur(chain[k]),
        .nxt(chain[k+1])
      );
    end
  endgenerate

  assign nxt = chain[STEPS];
endmodule

// File: rtl/lfsr_seed_guard.sv
// Replaces an all-zero seed, which would lock the register, by a default.
module lfsr_seed_guard #(
  parameter int unsigned      WIDTH        = 8,
  parameter logic [WIDTH-1:0] DEFAULT_SEED = 8'h01
) (
  input  logic [WIDTH-1:0] seed_in,
  output logic [WIDTH-1:0] seed_ok
);
  logic is_zero;

  assign is_zero = (seed_in == '0);
  assign seed_ok = is_zero ? DEFAULT_SEED : seed_in;
endmodule

// File: rtl/lfsr_multistep.sv
module lfsr_multistep #(
  parameter int unsigned      WIDTH        = 8,
  parameter logic [WIDTH-1:0] TAPS         = 8'b0111_0001,
  parameter int unsigned      STEPS        = 4,
  parameter logic [WIDTH-1:0] DEFAULT_SEED = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  input  logic             en,
  output logic [STEPS-1:0] lanes
);
  import lfsr_pkg::*;

  localparam int unsigned KEEP = WIDTH - STEPS;

  lfsr_op_e         op;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_adv;
  logic [WIDTH-1:0] seed_safe;

  lfsr_unroll #(
    .WIDTH(WIDTH),
    .TAPS (TAPS),
    .STEPS(STEPS)
  ) unroll_i (
    .cur(state_q),
    .nxt(state_adv)
  );

  lfsr_seed_guard #(
    .WIDTH       (WIDTH),
    .DEFAULT_SEED(DEFAULT_SEED)
  ) guard_i (
    .seed_in(seed),
    .seed_ok(seed_safe)
  );

  // Load wins over enable
  always_comb begin
    if (load)    op = OP_LOAD;
    else if (en) op = OP_ADVANCE;
    else         op = OP_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= DEFAULT_SEED;
    end else begin
      case (op)
        OP_LOAD:    state_q <= seed_safe;
        OP_ADVANCE: state_q <= state_adv;
        default:    state_q <= state_q;
      endcase
    end
  end

  assign lanes = state_q[STEPS-1:0];

  // Assertions next to the state register
  p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!load && !en) |=> $stable(state_q));

  p_load_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> (state_q != '0));

  p_load_value_r3: assert property (@(posedge clk) disable iff (rst)
    (load && seed != '0) |=> (state_q == $past(seed)));

  p_load_prio_r5: assert property (@(posedge clk) disable iff (rst)
    (load && en && seed != '0) |=> (state_q == $past(seed)));

  p_never_zero_r7: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

  generate
    if (KEEP > 0) begin : g_shift_chk
      p_advance_shift_r2: assert property (@(posedge clk) disable iff (rst)
        (en && !load) |=> (state_q[KEEP-1:0] == $past(state_q[WIDTH-1:STEPS])));
    end
  endgenerate
endmodule

// File: tb/lfsr_multistep_tb_top.sv
module lfsr_multistep_tb_top;
  logic       clk = 1'b0;
  logic       rst, load, en;
  logic [7:0] seed;
  logic [3:0] lanes_main;
  logic [1:0] lanes_small;
  logic [7:0] rm_main, rm_small;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  localparam logic [7:0] TAPS_M = 8'b0111_0001;
  localparam logic [7:0] TAPS_S = 8'b0000_1001;
  localparam logic [7:0] DEF_M  = 8'h5A;
  localparam logic [7:0] DEF_S  = 8'h03;

  always #4 clk = ~clk;

  lfsr_multistep #(.WIDTH(8), .TAPS(TAPS_M), .STEPS(4), .DEFAULT_SEED(DEF_M)) dut_i (
    .clk(clk), .rst(rst), .load(load), .seed(seed), .en(en), .lanes(lanes_main));

  lfsr_multistep #(.WIDTH(4), .TAPS(4'b1001), .STEPS(2), .DEFAULT_SEED(4'h3)) dut_small_i (
    .clk(clk), .rst(rst), .load(load), .seed(seed[3:0]), .en(en), .lanes(lanes_small));

  function automatic logic [7:0] ref_step(logic [7:0] s, logic [7:0] taps, int w);
    logic [7:0] n;
    n = s >> 1;
    n[w-1] = ^(s & taps);
    return n;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One clock: apply inputs, step the references, land past the edge
  task automatic cyc(logic ld, logic [7:0] sd, logic e);
    load = ld; seed = sd; en = e;
    @(posedge clk); #1;
    if (ld) begin
      rm_main  = (sd == 0) ? DEF_M : sd;
      rm_small = (sd[3:0] == 0) ? DEF_S : {4'h0, sd[3:0]};
    end else if (e) begin
      for (int k = 0; k < 4; k++) rm_main = ref_step(rm_main, TAPS_M, 8);
      for (int k = 0; k < 2; k++) rm_small = ref_step(rm_small, TAPS_S, 4);
    end
    load = 0; en = 0;
  endtask

  task automatic cmp_both(string req);
    chk(req, lanes_main, rm_main[3:0]);
    chk(req, lanes_small, rm_small[1:0]);
  endtask

  task automatic t_reset;
    rst = 1; load = 0; en = 0; seed = 0;
    repeat (2) @(posedge clk);
    #1 rst = 0;
    rm_main = DEF_M; rm_small = DEF_S;
    chk("R1 main reset", lanes_main, DEF_M[3:0]);
    chk("R1 small reset", lanes_small, DEF_S[1:0]);
  endtask

  task automatic t_run(logic [7:0] sd, int n);
    cyc(1, sd, 0);
    chk("R3 seed lanes", lanes_main, sd[3:0]);
    for (int i = 0; i < n; i++) begin
      cyc(0, 0, 1);
      cmp_both("R2 R7 advance");
    end
  endtask

  task automatic t_hold;
    logic [3:0] keep;
    keep = lanes_main;
    for (int i = 0; i < 5; i++) begin
      cyc(0, 0, 0);
      chk("R6 hold", lanes_main, keep);
    end
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 1);
      cmp_both("R6 resume after hold");
    end
  endtask

  task automatic t_load_prio;
    cyc(1, 8'hC7, 1);
    chk("R5 load over enable", lanes_main, 4'h7);
    chk("R5 load over enable small", lanes_small, 2'h3);
  endtask

  task automatic t_zero_seed;
    cyc(1, 8'h00, 0);
    chk("R4 zero seed main", lanes_main, DEF_M[3:0]);
    chk("R4 zero seed small", lanes_small, DEF_S[1:0]);
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 1);
      cmp_both("R4 advance from default");
    end
  endtask

  task automatic t_period;
    logic [3:0] rec [16];
    cyc(1, 8'h9D, 0);
    for (int i = 0; i < 16; i++) begin
      rec[i] = lanes_main;
      cyc(0, 0, 1);
    end
    for (int i = 16; i < 255; i++) cyc(0, 0, 1);
    for (int i = 0; i < 16; i++) begin
      chk("R7 period 255", lanes_main, rec[i]);
      cyc(0, 0, 1);
    end
  endtask

  task automatic t_small_eq;
    // seed 1011 -> 1010 -> 0110 under the two-step equations
    cyc(1, 8'h0B, 0);
    cyc(0, 0, 1);
    chk("R8 first step", lanes_small, 2'b10);
    cyc(0, 0, 1);
    chk("R8 second step", lanes_small, 2'b10);
    cyc(0, 0, 1);
    cmp_both("R8 against reference");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_run(8'h01, 40);
    t_run(8'hE3, 40);
    t_hold();
    t_load_prio();
    t_zero_seed();
    t_run(8'h6E, 20);
    t_period();
    t_small_eq();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule